// File: doc/BRIEF.md
# I2C Bus Status Flag Monitor

This block watches the clock and data lines of an I2C bus and keeps an 8-bit status byte that a host can read. Both lines pass through a synchronizer. The block then looks for START and STOP conditions, tracks whether the bus is occupied, and keeps two sticky flags. One flag records a START that arrives while the bus is already occupied (a repeated start). The other records lost arbitration.

The host clears the sticky flags by writing 0 to the interrupt-flag bit of a neighbouring control register. The host-write strobe and the written value come into this block as two inputs. The transmitter signals lost arbitration with a one-cycle pulse. The address decoder signals that no slave addressing took place with a one-cycle pulse. A master-start request that arrives while the bus is occupied counts as lost arbitration. The lower five bits of the byte belong to logic outside this block and read as zero.

Top module: `i2c_status_mon`

## Requirements
- R1: After reset the status byte is 0x00. No input writes it directly; it changes only through the rules below.
- R2: Bit layout: bit 7 is bus-busy, bit 6 is repeated-start and bit 5 is arbitration-lost. Bits 4 to 0 always read 0.
- R3: A START condition sets bus-busy. A START is SDA falling while SCL is high, observed after the SYNC_STAGES-flop synchronizer. The flag is visible SYNC_STAGES+1 clock edges after the line change.
- R4: A STOP condition clears bus-busy. A STOP is SDA rising while SCL is high.
- R5: A START seen while bus-busy is 1 sets repeated-start.
- R6: Any one of these clears repeated-start: a host write of 0 to the interrupt-flag bit (host_wr_int=1 with host_wr_val=0), an addressing-miss pulse, a START on an idle bus, or a STOP.
- R7: An arbitration-lost pulse sets arbitration-lost. A master-start request while bus-busy is 1 also sets it. A master-start request on an idle bus has no effect.
- R8: Only a host write of 0 to the interrupt-flag bit clears arbitration-lost. A host write of 1, a STOP, a START and an addressing-miss pulse all leave it unchanged.
- R9: When a set event and a clear event for the same flag arrive in the same cycle, the flag ends up at 1.
- R10: SDA changes while SCL is low are data bits and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| host_wr_int | input | 1 | Host write strobe for the interrupt-flag bit |
| host_wr_val | input | 1 | Value the host writes to the interrupt-flag bit |
| master_req | input | 1 | One-cycle pulse: host requests a master start |
| arb_lost_pulse | input | 1 | One-cycle pulse: transmitter lost arbitration |
| addr_miss_pulse | input | 1 | One-cycle pulse: no slave addressing occurred |
| status_o | output | 8 | Status byte {busy, rsc, al, 5'b0} |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It derives its bus-event alignment from that parameter, so a START can be placed in exactly the same cycle as an addressing-miss pulse, and a master request or lost-arbitration pulse in the same cycle as a host clear. This brings the set-wins rule within reach for both sticky flags. Random sequences of START, STOP, data bits, host writes and pulses run the clear sources of the repeated-start flag against the narrow clear source of arbitration-lost, across both idle and occupied bus states.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int BUSY_BIT = 7;
  localparam int RSC_BIT  = 6;
  localparam int AL_BIT   = 5;
  localparam int LOW_W    = AL_BIT;

  typedef struct packed {
    logic busy;
    logic rsc;
    logic al;
  } flags_t;

  // Sticky flag update: a set event wins over a clear event.
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  // SDA falls while SCL stays high.
  function automatic logic is_start(logic scl_prev, logic scl_now,
                                    logic sda_prev, logic sda_now);
    return scl_prev & scl_now & sda_prev & ~sda_now;
  endfunction

  // SDA rises while SCL stays high.
  function automatic logic is_stop(logic scl_prev, logic scl_now,
                                   logic sda_prev, logic sda_now);
    return scl_prev & scl_now & ~sda_prev & sda_now;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(flags_t f);
    logic [STAT_W-1:0] s;
    s = '0;
    s[BUSY_BIT] = f.busy;
    s[RSC_BIT]  = f.rsc;
    s[AL_BIT]   = f.al;
    return s;
  endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d_in,
  output logic [LANES-1:0] d_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;  // idle bus lines are high
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
  import i2c_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_det = is_start(scl_q, scl_s, sda_q, sda_s);
  assign stop_det  = is_stop(scl_q, scl_s, sda_q, sda_s);

  // R10
  no_event_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_s |-> (!start_det && !stop_det));
endmodule

// File: rtl/status_flags.sv
module status_flags
  import i2c_stat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_det,
  input  logic   stop_det,
  input  logic   host_clr,
  input  logic   addr_miss,
  input  logic   arb_lost,
  input  logic   master_req,
  output flags_t flags
);
  logic rsc_set, rsc_clr, al_set, al_clr;

  assign rsc_set = start_det & flags.busy;
  assign rsc_clr = host_clr | addr_miss | stop_det | (start_det & ~flags.busy);
  assign al_set  = arb_lost | (master_req & flags.busy);
  assign al_clr  = host_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.busy <= sticky_next(flags.busy, start_det, stop_det);
      flags.rsc  <= sticky_next(flags.rsc, rsc_set, rsc_clr);
      flags.al   <= sticky_next(flags.al, al_set, al_clr);
    end
  end

  // R3
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> flags.busy);
  // R4
  busy_off_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> !flags.busy);
  // R5
  rsc_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && flags.busy) |=> flags.rsc);
  // R6
  rsc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || addr_miss || host_clr) && !(start_det && flags.busy) |=> !flags.rsc);
  // R7
  al_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> flags.al);
  // R8
  al_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.al && !host_clr) |=> flags.al);
  // R9
  al_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && host_clr) |=> flags.al);
endmodule

// File: rtl/i2c_status_mon.sv
module i2c_status_mon
  import i2c_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              host_wr_int,
  input  logic              host_wr_val,
  input  logic              master_req,
  input  logic              arb_lost_pulse,
  input  logic              addr_miss_pulse,
  output logic [STAT_W-1:0] status_o
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       start_det, stop_det;
  logic       host_clr;
  flags_t     flags;

  line_sync #(.STAGES(SYNC_STAGES), .LANES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .d_out (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  bus_cond_detect u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign host_clr = host_wr_int & ~host_wr_val;

  status_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .host_clr   (host_clr),
    .addr_miss  (addr_miss_pulse),
    .arb_lost   (arb_lost_pulse),
    .master_req (master_req),
    .flags      (flags)
  );

  assign status_o = pack_status(flags);

  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[LOW_W-1:0] == '0);
endmodule

// File: tb/sim_i2c_status_mon.sv
`timescale 1ns/1ps
module sim_i2c_status_mon;
  localparam int SYNC = 2;
  localparam int HOLD = SYNC + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic host_wr_int = 1'b0, host_wr_val = 1'b0;
  logic master_req = 1'b0, arb_lost_pulse = 1'b0, addr_miss_pulse = 1'b0;
  logic [7:0] status_o;

  int n_run = 0, n_fail = 0;
  bit m_busy = 0, m_rsc = 0, m_al = 0;

  always #2 clk = ~clk;

  i2c_status_mon #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .host_wr_int(host_wr_int), .host_wr_val(host_wr_val),
    .master_req(master_req), .arb_lost_pulse(arb_lost_pulse),
    .addr_miss_pulse(addr_miss_pulse), .status_o(status_o)
  );

  function automatic logic [7:0] expect_byte(bit b, bit r, bit a);
    return {b, r, a, 5'b00000};
  endfunction

  task automatic check(string tag);
    logic [7:0] exp;
    exp = expect_byte(m_busy, m_rsc, m_al);
    n_run++;
    if (status_o !== exp) begin
      n_fail++;
      $display("FAIL %s: status actual %02h expected %02h", tag, status_o, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_lines(logic c, logic d);
    @(negedge clk);
    scl_in = c;
    sda_in = d;
    wait_cyc(HOLD);
  endtask

  task automatic bus_start();
    if (!scl_in) begin
      set_lines(1'b0, 1'b1);
      set_lines(1'b1, 1'b1);
    end else if (!sda_in) begin
      set_lines(1'b0, 1'b0);
      set_lines(1'b0, 1'b1);
      set_lines(1'b1, 1'b1);
    end
    set_lines(1'b1, 1'b0);
    m_rsc = m_busy;
    m_busy = 1'b1;
    set_lines(1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    set_lines(1'b0, sda_in);
    set_lines(1'b0, 1'b0);
    set_lines(1'b1, 1'b0);
    set_lines(1'b1, 1'b1);
    m_busy = 1'b0;
    m_rsc = 1'b0;
  endtask

  task automatic bus_data(logic bitv);
    set_lines(1'b0, sda_in);
    set_lines(1'b0, bitv);
    set_lines(1'b1, bitv);
    set_lines(1'b0, bitv);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: begin host_wr_int = 1; host_wr_val = 0; end
      1: begin host_wr_int = 1; host_wr_val = 1; end
      2: addr_miss_pulse = 1;
      3: arb_lost_pulse = 1;
      default: master_req = 1;
    endcase
    @(negedge clk);
    host_wr_int = 0; host_wr_val = 0;
    addr_miss_pulse = 0; arb_lost_pulse = 0; master_req = 0;
    wait_cyc(2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int op;
    void'($urandom(32'd1234));
    wait_cyc(3);
    check("R1 reset value");
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1 after release");

    // R10: data toggles on idle-ish bus with SCL low change nothing
    bus_data(1'b0);
    bus_data(1'b1);
    check("R10 data on idle bus");
    bus_start();
    check("R3 start sets busy, R2 layout");
    bus_data(1'b1);
    bus_data(1'b0);
    check("R10 data while busy");
    bus_start();
    check("R5 repeated start");
    pulse(2);
    m_rsc = 0;
    check("R6 addr miss clears rsc");
    pulse(4);
    m_al = 1;
    check("R7 master req while busy");
    bus_stop();
    check("R4 stop clears busy, R8 al kept");
    pulse(2);
    check("R8 addr miss leaves al");
    pulse(1);
    check("R8 host write 1 leaves al");
    pulse(0);
    m_al = 0;
    check("R8 host write 0 clears al");
    pulse(4);
    check("R7 master req idle has no effect");

    // R9: arbitration pulse together with host clear
    pulse(3);
    @(negedge clk);
    arb_lost_pulse = 1; host_wr_int = 1; host_wr_val = 0;
    @(negedge clk);
    arb_lost_pulse = 0; host_wr_int = 0;
    wait_cyc(2);
    m_al = 1;
    check("R9 al set wins over host clear");
    pulse(0);
    m_al = 0;
    check("R8 clear before R9 rsc case");

    // R9: repeated START aligned with an addressing-miss pulse
    bus_start();
    set_lines(1'b0, 1'b1);
    set_lines(1'b1, 1'b1);
    @(negedge clk);
    sda_in = 1'b0;
    for (int i = 0; i < SYNC; i++) @(posedge clk);
    @(negedge clk);
    addr_miss_pulse = 1;
    @(negedge clk);
    addr_miss_pulse = 0;
    wait_cyc(2);
    m_rsc = 1;
    check("R9 rsc set wins over addr miss");
    set_lines(1'b0, 1'b0);
    pulse(0);
    m_rsc = 0;
    check("R6 host write 0 clears rsc");
    bus_start();
    bus_stop();
    bus_start();
    check("R6 start on idle bus leaves rsc clear");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      op = $urandom_range(0, 7);
      case (op)
        0: begin bus_start(); check("R3/R5/R6 random start"); end
        1: begin bus_stop(); check("R4/R6 random stop"); end
        2: begin bus_data(1'($urandom_range(0, 1))); check("R10 random data"); end
        3: begin pulse(0); m_rsc = 0; m_al = 0; check("R6/R8 random host clear"); end
        4: begin pulse(1); check("R8 random host write 1"); end
        5: begin pulse(2); m_rsc = 0; check("R6 random addr miss"); end
        6: begin pulse(3); m_al = 1; check("R7 random arb lost"); end
        default: begin pulse(4); if (m_busy) m_al = 1; check("R7 random master req"); end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule